// File: doc/BRIEF.md
# Victim Aggressor Pattern Generator

This engine fills a run of consecutive lines of a 64-line test-pattern buffer with crosstalk patterns built from two 32-lane masks: an aggressor mask and a victim mask. Each lane of a line is turned into an 8-bit code by a small table. Chunk `c` of the line is the 32-bit word made of bit `c` of every lane code, placed twice side by side to fill 64 bits. The engine writes the eight chunks of a line, one per cycle, then rotates both masks left by one lane and moves to the next line. A job covers as many lines as its rotation count asks for, starting at a given line.

A built-in sequencer can also run the standard fill: ten back-to-back jobs that cover lines 0 to 61. The output is a plain chunk-write strobe with line, chunk index and data, plus a one-cycle done pulse and a sticky overflow flag.

The controller is a four-state machine. IDLE waits for a request. A single-job request (`start_i`) goes to WRITE, or straight to FINISH when the rotation count is zero. A standard-fill request (`std_start_i`) goes to NEXT_JOB. NEXT_JOB loads the next job from the sequencer and goes to WRITE. WRITE emits one chunk per cycle. After the last chunk of the last line it goes to NEXT_JOB if standard-fill jobs remain, and to FINISH otherwise. FINISH raises done for one cycle and returns to IDLE.

Top module: `va_pattern_gen`

## Requirements
- R1: Lane b is coded by a table indexed by {NOT victim[b], aggressor[b]} (victim bit as the index MSB): index 0 gives 0xAA, 1 gives 0xC0, 2 gives 0xCC and 3 gives 0xF0.
- R2: Bit b of chunk c's word equals bit c of lane b's code. `wr_data_o` carries that 32-bit word in both bits 63:32 and bits 31:0.
- R3: A job with rotation count N and start line S writes lines S, S+1, … S+N-1 in that order. Each line is written as chunks 0 to 7 on consecutive cycles, and the first write is in the cycle after the request is accepted.
- R4: After each line, both masks rotate left by one lane, with lane 31 wrapping into lane 0.
- R5: A job with a rotation count of 0 makes no writes and raises done in the cycle after the request.
- R6: A write whose line address is 64 or more is suppressed (`wr_valid_o` stays low for that cycle). `overflow_o` then rises and stays high until the next request is accepted.
- R7: The standard fill first writes 8 lines from line 0 with aggressor 0 and victim 0x01010101. It then writes 9 groups of 6 lines with victim 0x41041041; group a starts at line 8+6a and uses the aggressor masks 0x86186186, 0x18618618, 0x30C30C30, 0xA28A28A2, 0x8A28A28A, 0x14514514, 0x28A28A28, 0x92492492 and 0x24924924 in that order. One idle cycle separates the jobs.
- R8: `done_o` is a one-cycle pulse in the cycle after the last write slot, and no write occurs in that cycle.
- R9: After reset the engine is idle, with `busy_o`, `wr_valid_o`, `done_o` and `overflow_o` all low.
- R10: Requests that arrive while `busy_o` is high are ignored, and the running job goes on unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a single job from the inputs below |
| std_start_i | input | 1 | Start the standard fill (ignored if start_i is also high) |
| agg_i | input | 32 | Aggressor mask |
| vic_i | input | 32 | Victim mask |
| rot_i | input | ROT_W | Number of lines (rotation count) |
| line_i | input | SLINE_W | First line address |
| busy_o | output | 1 | Engine is not idle |
| wr_valid_o | output | 1 | Chunk write strobe |
| wr_line_o | output | LINE_W | Line being written |
| wr_chunk_o | output | 3 | Chunk index within the line |
| wr_data_o | output | 64 | Chunk data |
| done_o | output | 1 | Job or fill complete (one cycle) |
| overflow_o | output | 1 | A write was suppressed for an out-of-range line |

## Verification
The bench builds the block with its defaults: 64 lines, an 8-bit start line and an 8-bit rotation count. An 8-bit start line can point well past line 63, so the bench can place jobs that cross the top of the buffer or lie wholly beyond it, and so reach the suppression and overflow behaviour. An 8-bit rotation count allows a 33-line job, which shows the masks wrapping through all 32 lanes and coming back to the start.

// File: rtl/va_pkg.sv
package va_pkg;

    localparam int LANES   = 32;
    localparam int CHUNKS  = 8;
    localparam int CHUNK_W = $clog2(CHUNKS);
    localparam int WORD_W  = 2 * LANES;
    localparam int STD_JOBS = 10;
    localparam int JOB_W   = $clog2(STD_JOBS);

    typedef enum logic [1:0] {
        S_IDLE,
        S_WRITE,
        S_NEXT_JOB,
        S_FINISH
    } va_state_e;

    // Lane code table, indexed by {~victim, aggressor}
    function automatic logic [CHUNKS-1:0] lane_code(input logic vic, input logic agg);
        logic [CHUNKS-1:0] code;
        case ({~vic, agg})
            2'd0:    code = 8'hAA;
            2'd1:    code = 8'hC0;
            2'd2:    code = 8'hCC;
            default: code = 8'hF0;
        endcase
        return code;
    endfunction

    function automatic logic [LANES-1:0] rotl1(input logic [LANES-1:0] m);
        return {m[LANES-2:0], m[LANES-1]};
    endfunction

endpackage

// File: rtl/va_chunk_encoder.sv
module va_chunk_encoder
    import va_pkg::*;
(
    input  logic [LANES-1:0]   agg,
    input  logic [LANES-1:0]   vic,
    input  logic [CHUNK_W-1:0] chunk,
    output logic [WORD_W-1:0]  word
);

    logic [LANES-1:0] half;

    for (genvar b = 0; b < LANES; b++) begin : g_lane
        logic [CHUNKS-1:0] code;
        assign code    = lane_code(vic[b], agg[b]);
        assign half[b] = code[chunk];
    end

    assign word = {half, half};

endmodule

// File: rtl/va_std_seq.sv
module va_std_seq
    import va_pkg::*;
#(
    parameter int ROT_W   = 8,
    parameter int SLINE_W = 8
) (
    input  logic [JOB_W-1:0]   job,
    output logic [LANES-1:0]   agg,
    output logic [LANES-1:0]   vic,
    output logic [ROT_W-1:0]   rot,
    output logic [SLINE_W-1:0] line,
    output logic               last
);

    localparam int FIRST_LINES = 8;
    localparam int GROUP_LINES = 6;

    always_comb begin
        case (job)
            4'd1:    agg = 32'h86186186;
            4'd2:    agg = 32'h18618618;
            4'd3:    agg = 32'h30C30C30;
            4'd4:    agg = 32'hA28A28A2;
            4'd5:    agg = 32'h8A28A28A;
            4'd6:    agg = 32'h14514514;
            4'd7:    agg = 32'h28A28A28;
            4'd8:    agg = 32'h92492492;
            4'd9:    agg = 32'h24924924;
            default: agg = '0;
        endcase
        if (job == '0) begin
            vic  = 32'h01010101;
            rot  = ROT_W'(FIRST_LINES);
            line = '0;
        end else begin
            vic  = 32'h41041041;
            rot  = ROT_W'(GROUP_LINES);
            line = SLINE_W'(FIRST_LINES + GROUP_LINES * (int'(job) - 1));
        end
        last = (job == JOB_W'(STD_JOBS - 1));
    end

endmodule

// File: rtl/va_pattern_gen.sv
module va_pattern_gen
    import va_pkg::*;
#(
    parameter int NUM_LINES = 64,
    parameter int ROT_W     = 8,
    parameter int SLINE_W   = 8,
    localparam int LINE_W   = $clog2(NUM_LINES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               std_start_i,
    input  logic [31:0]        agg_i,
    input  logic [31:0]        vic_i,
    input  logic [ROT_W-1:0]   rot_i,
    input  logic [SLINE_W-1:0] line_i,
    output logic               busy_o,
    output logic               wr_valid_o,
    output logic [LINE_W-1:0]  wr_line_o,
    output logic [2:0]         wr_chunk_o,
    output logic [63:0]        wr_data_o,
    output logic               done_o,
    output logic               overflow_o
);

    localparam int SUM_W = ((SLINE_W > ROT_W) ? SLINE_W : ROT_W) + 1;
    localparam logic [CHUNK_W-1:0] LAST_CHUNK = CHUNK_W'(CHUNKS - 1);

    va_state_e state_q, state_d;

    logic [LANES-1:0]   agg_q, vic_q;
    logic [ROT_W-1:0]   rot_q, v_q;
    logic [SLINE_W-1:0] base_q;
    logic [CHUNK_W-1:0] chunk_q;
    logic [JOB_W-1:0]   job_q;
    logic               std_q, last_job_q, ovf_q;

    logic [SUM_W-1:0]   line_sum;
    logic               in_range, line_end, job_end, accept_single, accept_std;

    logic [LANES-1:0]   seq_agg, seq_vic;
    logic [ROT_W-1:0]   seq_rot;
    logic [SLINE_W-1:0] seq_line;
    logic               seq_last;
    logic [WORD_W-1:0]  enc_word;

    va_std_seq #(.ROT_W(ROT_W), .SLINE_W(SLINE_W)) u_seq (
        .job  (job_q),
        .agg  (seq_agg),
        .vic  (seq_vic),
        .rot  (seq_rot),
        .line (seq_line),
        .last (seq_last)
    );

    va_chunk_encoder u_enc (
        .agg   (agg_q),
        .vic   (vic_q),
        .chunk (chunk_q),
        .word  (enc_word)
    );

    assign line_sum      = SUM_W'(base_q) + SUM_W'(v_q);
    assign in_range      = line_sum < SUM_W'(NUM_LINES);
    assign line_end      = (chunk_q == LAST_CHUNK);
    assign job_end       = line_end && (v_q == rot_q - ROT_W'(1));
    assign accept_single = (state_q == S_IDLE) && start_i;
    assign accept_std    = (state_q == S_IDLE) && !start_i && std_start_i;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (start_i)
                    state_d = (rot_i == '0) ? S_FINISH : S_WRITE;
                else if (std_start_i)
                    state_d = S_NEXT_JOB;
            end
            S_WRITE: begin
                if (job_end)
                    state_d = (std_q && !last_job_q) ? S_NEXT_JOB : S_FINISH;
            end
            S_NEXT_JOB: state_d = S_WRITE;
            S_FINISH:   state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Job datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            agg_q      <= '0;
            vic_q      <= '0;
            rot_q      <= '0;
            base_q     <= '0;
            v_q        <= '0;
            chunk_q    <= '0;
            job_q      <= '0;
            std_q      <= 1'b0;
            last_job_q <= 1'b0;
            ovf_q      <= 1'b0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (start_i) begin
                        agg_q   <= agg_i;
                        vic_q   <= vic_i;
                        rot_q   <= rot_i;
                        base_q  <= line_i;
                        v_q     <= '0;
                        chunk_q <= '0;
                        std_q   <= 1'b0;
                        ovf_q   <= 1'b0;
                    end else if (std_start_i) begin
                        job_q   <= '0;
                        std_q   <= 1'b1;
                        ovf_q   <= 1'b0;
                    end
                end
                S_NEXT_JOB: begin
                    agg_q      <= seq_agg;
                    vic_q      <= seq_vic;
                    rot_q      <= seq_rot;
                    base_q     <= seq_line;
                    last_job_q <= seq_last;
                    job_q      <= job_q + JOB_W'(1);
                    v_q        <= '0;
                    chunk_q    <= '0;
                end
                S_WRITE: begin
                    if (!in_range) ovf_q <= 1'b1;
                    chunk_q <= chunk_q + CHUNK_W'(1);
                    if (line_end) begin
                        v_q   <= v_q + ROT_W'(1);
                        agg_q <= rotl1(agg_q);
                        vic_q <= rotl1(vic_q);
                    end
                end
                S_FINISH: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy_o     = (state_q != S_IDLE);
        wr_valid_o = (state_q == S_WRITE) && in_range;
        wr_line_o  = line_sum[LINE_W-1:0];
        wr_chunk_o = 3'(chunk_q);
        wr_data_o  = enc_word;
        done_o     = (state_q == S_FINISH);
        overflow_o = ovf_q;
    end

    // Assertions
    assert_chunk_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_o && wr_chunk_o != 3'd7) |=> (wr_valid_o && wr_chunk_o == $past(wr_chunk_o) + 3'd1));

    assert_mask_rotate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WRITE && line_end && !job_end) |=>
            (agg_q == rotl1($past(agg_q)) && vic_q == rotl1($past(vic_q))));

    assert_zero_rot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && start_i && rot_i == '0) |=> (done_o && !wr_valid_o));

    assert_suppress_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WRITE && !wr_valid_o) |=> overflow_o);

    assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow_o && !accept_single && !accept_std) |=> overflow_o);

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !wr_valid_o);

    assert_busy_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WRITE) |=> ($stable(base_q) && $stable(rot_q)));

endmodule

// File: tb/va_pattern_gen_bench.sv
module va_pattern_gen_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0, std_start_i = 1'b0;
    logic [31:0] agg_i = '0, vic_i = '0;
    logic [7:0]  rot_i = '0, line_i = '0;
    logic        busy_o, wr_valid_o, done_o, overflow_o;
    logic [5:0]  wr_line_o;
    logic [2:0]  wr_chunk_o;
    logic [63:0] wr_data_o;

    int n_tests = 0, n_fail = 0;
    int n_written = 0, max_line = 0;
    bit finished = 0;

    always #10 clk = ~clk;   // 50 MHz

    va_pattern_gen u_va_pattern_gen (
        .clk, .rst_n, .start_i, .std_start_i, .agg_i, .vic_i, .rot_i, .line_i,
        .busy_o, .wr_valid_o, .wr_line_o, .wr_chunk_o, .wr_data_o, .done_o, .overflow_o
    );

    localparam int NV = 6;
    localparam logic [31:0] T_AGG [NV] = '{32'h0, 32'hFFFFFFFF, 32'h12345678, 32'h80000001, 32'h0, 32'hA5A5A5A5};
    localparam logic [31:0] T_VIC [NV] = '{32'h0, 32'hFFFFFFFF, 32'h9ABCDEF0, 32'h00000001, 32'hFFFFFFFF, 32'h5A5A5A5A};
    localparam int          T_ROT [NV] = '{1, 2, 3, 33, 4, 2};
    localparam int          T_LIN [NV] = '{0, 5, 20, 10, 63, 200};

    localparam logic [31:0] STD_AGG [9] = '{32'h86186186, 32'h18618618, 32'h30C30C30,
        32'hA28A28A2, 32'h8A28A28A, 32'h14514514, 32'h28A28A28, 32'h92492492, 32'h24924924};

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] code_of(input logic v, input logic a);
        if (!v && !a) return 8'hCC;
        if (!v &&  a) return 8'hF0;
        if ( v && !a) return 8'hAA;
        return 8'hC0;
    endfunction

    function automatic logic [63:0] exp_word(input logic [31:0] a, input logic [31:0] v, input int c);
        logic [31:0] w;
        for (int b = 0; b < 32; b++) begin
            logic [7:0] cd;
            cd   = code_of(v[b], a[b]);
            w[b] = cd[c];
        end
        return {w, w};
    endfunction

    // Called at the falling edge of the first write slot; returns at the falling edge after the last
    task automatic expect_lines(input logic [31:0] a0, input logic [31:0] v0, input int rot, input int sl);
        logic [31:0] a, v;
        a = a0; v = v0;
        for (int ln = 0; ln < rot; ln++) begin
            for (int c = 0; c < 8; c++) begin
                int line;
                line = sl + ln;
                chk("R6 valid", 64'(wr_valid_o), 64'(line < 64));
                if (line < 64) begin
                    chk("R3 line", 64'(wr_line_o), 64'(line));
                    chk("R3 chunk", 64'(wr_chunk_o), 64'(c));
                    chk("R1 R2 R4 data", wr_data_o, exp_word(a, v, c));
                    n_written++;
                    if (line > max_line) max_line = line;
                end
                @(negedge clk);
            end
            a = {a[30:0], a[31]};
            v = {v[30:0], v[31]};
        end
    endtask

    task automatic single(input logic [31:0] a, input logic [31:0] v, input int rot, input int sl);
        agg_i = a; vic_i = v; rot_i = 8'(rot); line_i = 8'(sl);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++; n_tests++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        chk("R9 busy", 64'(busy_o), 0);
        chk("R9 valid", 64'(wr_valid_o), 0);
        chk("R9 done", 64'(done_o), 0);
        chk("R9 overflow", 64'(overflow_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 idle after release", 64'(busy_o), 0);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            bit ovf;
            ovf = (T_LIN[i] + T_ROT[i] - 1) >= 64;
            single(T_AGG[i], T_VIC[i], T_ROT[i], T_LIN[i]);
            expect_lines(T_AGG[i], T_VIC[i], T_ROT[i], T_LIN[i]);
            chk("R8 done", 64'(done_o), 1);
            chk("R8 no write at done", 64'(wr_valid_o), 0);
            chk("R6 overflow", 64'(overflow_o), 64'(ovf));
            @(negedge clk);
            chk("R8 done pulse", 64'(done_o), 0);
            chk("R6 overflow sticky", 64'(overflow_o), 64'(ovf));
        end

        // R6: overflow cleared by next accepted request
        single(32'h1, 32'h2, 1, 0);
        expect_lines(32'h1, 32'h2, 1, 0);
        chk("R6 overflow cleared", 64'(overflow_o), 0);
        @(negedge clk);

        // R5: zero rotation count
        single(32'hDEADBEEF, 32'h1, 0, 3);
        chk("R5 done at once", 64'(done_o), 1);
        chk("R5 no write", 64'(wr_valid_o), 0);
        @(negedge clk);
        chk("R5 idle", 64'(busy_o), 0);

        // R10: requests while busy are ignored
        single(32'hF0F0F0F0, 32'h0F0F0F0F, 3, 30);
        fork
            expect_lines(32'hF0F0F0F0, 32'h0F0F0F0F, 3, 30);
            begin
                repeat (4) @(negedge clk);
                agg_i = 32'h0; vic_i = 32'hFFFFFFFF; rot_i = 8'd9; line_i = 8'd0;
                start_i = 1'b1; std_start_i = 1'b1;
                @(negedge clk);
                start_i = 1'b0; std_start_i = 1'b0;
            end
        join
        chk("R10 job completes unchanged", 64'(done_o), 1);
        @(negedge clk);
        chk("R10 back to idle", 64'(busy_o), 0);

        // R7: standard fill
        n_written = 0; max_line = 0;
        std_start_i = 1'b1;
        @(negedge clk);
        std_start_i = 1'b0;
        chk("R7 gap before job", 64'(wr_valid_o), 0);
        @(negedge clk);
        expect_lines(32'h0, 32'h01010101, 8, 0);
        for (int g = 0; g < 9; g++) begin
            chk("R7 gap between jobs", 64'(wr_valid_o | done_o), 0);
            @(negedge clk);
            expect_lines(STD_AGG[g], 32'h41041041, 6, 8 + 6 * g);
        end
        chk("R7 done", 64'(done_o), 1);
        chk("R7 no overflow", 64'(overflow_o), 0);
        chk("R7 write count", 64'(n_written), 62 * 8);
        chk("R7 last line", 64'(max_line), 61);
        @(negedge clk);
        chk("R9 idle after fill", 64'(busy_o), 0);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule